// File: doc/BRIEF.md
# Serdes Control-Port Lane Override Sequencer

This block brings two serdes PHYs out of reset configuration without software involvement. Each PHY has a parallel control-register port with a select line, an address bus, a write-data bus, a write-enable line and an acknowledge line. A single start pulse makes the sequencer enable both select lines and wait a settle time. It then performs a fixed program of eight register writes: the receiver override register of each of the four lanes, first on PHY 0 and then on PHY 1.

Each write is a four-phase handshake. Address and data are placed on the bus, write-enable rises, and the sequencer polls acknowledge until it is high. It then drops write-enable and polls until acknowledge is low again. Polling happens on a fixed interval. Each wait gives up after a set number of polls. A wait that gives up sets a sticky timeout flag, and the program still carries on, so a dead PHY cannot hang bring-up. The block has no streaming data path. Start, busy, done and timeout are plain level and pulse signals, and the only flow control is the enable/acknowledge handshake on each control port.

Top module: `phy_cr_init_seq`

## Requirements
- R1: After reset, busy, done, timeout, both select lines and both write-enables are 0, and both address and data buses read 0.
- R2: A start pulse accepted while idle makes busy 1 and drives both select lines to 1 on the next cycle. The select lines then stay 1 until reset, and a write-enable is only ever high on a PHY whose select is 1.
- R3: The first write-enable rises at least SETTLE_CYC cycles after the select lines go high.
- R4: The program makes exactly eight writes, one at a time: PHY 0 lanes 0,1,2,3 and then PHY 1 lanes 0,1,2,3. At most one write-enable is high at any time, and it is on the PHY being written.
- R5: The address of lane n is 0x1008 + 0x100·n, and every write carries data 0x0E21, which has bits 0, 5, 9, 10 and 11 set and all other bits clear.
- R6: Address and data are valid on the targeted PHY's bus at least one cycle before write-enable rises, and they stay unchanged while write-enable is high.
- R7: Write-enable falls only after acknowledge was sampled high at a poll, or after that wait times out. The next write starts only after acknowledge was sampled low at a poll, or after that wait times out.
- R8: Acknowledge is sampled every POLL_CYC cycles, and the first sample comes POLL_CYC cycles after the wait begins. A wait with no response ends after TIMEOUT_POLLS samples, so a write-enable that gets no acknowledge stays high for exactly POLL_CYC·TIMEOUT_POLLS cycles. The timeout flag is then set and the program continues.
- R9: The timeout flag stays set through the end of the program and while idle, and it clears only when the next start is accepted.
- R10: After the eighth handshake, done is high for exactly one cycle, in the same cycle that busy returns to 0.
- R11: A start pulse while busy is ignored. The program is not restarted or lengthened, and only one done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, also the control-port clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start the program (ignored while busy) |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | One-cycle pulse at program end |
| timeout_o | output | 1 | Sticky: some acknowledge wait gave up |
| cr_sel_o | output | NUM_PHY | Control-port select per PHY |
| cr_addr_o | output | NUM_PHY*ADDR_W | Address bus per PHY, PHY p at [p*ADDR_W +: ADDR_W] |
| cr_wdata_o | output | NUM_PHY*DATA_W | Write-data bus per PHY, PHY p at [p*DATA_W +: DATA_W] |
| cr_wen_o | output | NUM_PHY | Write-enable per PHY |
| cr_ack_i | input | NUM_PHY | Acknowledge per PHY |

## Verification
A wrong write index or wrong phase state shows up on the buses within one handshake. It appears as a wrong lane address, a write on the wrong PHY, or a write-enable dropped before acknowledge was sampled. A poll counter that is off by even one cycle changes the exact write-enable high time seen with a silent PHY, so that time is measured against POLL_CYC·TIMEOUT_POLLS. A timeout flag that is lost or cleared early is visible at done, and again on the idle cycles before the next start.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SETUP,
    ST_ACK_HI,
    ST_ACK_LO
  } seq_state_e;

  // receiver override bit positions
  localparam int unsigned BIT_CDR_TRACK = 0;
  localparam int unsigned BIT_LOS_LEVEL = 5;
  localparam int unsigned BIT_TERM_ON   = 9;
  localparam int unsigned BIT_TERM_AC   = 10;
  localparam int unsigned BIT_PHY_ON    = 11;

  function automatic logic [31:0] rx_ovrd_word();
    logic [31:0] w;
    w = '0;
    w[BIT_CDR_TRACK] = 1'b1;
    w[BIT_LOS_LEVEL] = 1'b1;
    w[BIT_TERM_ON]   = 1'b1;
    w[BIT_TERM_AC]   = 1'b1;
    w[BIT_PHY_ON]    = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/phy_cr_poll_timer.sv
module phy_cr_poll_timer #(
  parameter int unsigned POLL_CYC      = 500,
  parameter int unsigned TIMEOUT_POLLS = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic tick_o,
  output logic last_o
);
  localparam int unsigned POLL_W = $clog2(POLL_CYC + 1);
  localparam int unsigned TRY_W  = $clog2(TIMEOUT_POLLS + 1);
  localparam logic [POLL_W-1:0] POLL_END = POLL_W'(POLL_CYC - 1);
  localparam logic [TRY_W-1:0]  TRY_END  = TRY_W'(TIMEOUT_POLLS - 1);

  logic [POLL_W-1:0] poll_q;
  logic [TRY_W-1:0]  try_q;

  assign tick_o = run_i && (poll_q == POLL_END);
  assign last_o = (try_q == TRY_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= '0;
      try_q  <= '0;
    end else if (restart_i) begin
      poll_q <= '0;
      try_q  <= '0;
    end else if (run_i) begin
      if (poll_q == POLL_END) begin
        poll_q <= '0;
        if (try_q != TRY_END) try_q <= try_q + 1'b1;
      end else begin
        poll_q <= poll_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_cr_write_plan.sv
module phy_cr_write_plan #(
  parameter int unsigned NUM_LANE    = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned IDX_W       = 3,
  parameter int unsigned PHY_W       = 1,
  parameter int unsigned ADDR_BASE   = 32'h1008,
  parameter int unsigned LANE_STRIDE = 32'h100
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHY_W-1:0]  phy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [31:0] WORD = phy_cr_pkg::rx_ovrd_word();

  logic [31:0] lane_num;
  logic [31:0] addr_full;

  always_comb begin
    lane_num  = 32'(idx_i) % NUM_LANE;
    addr_full = ADDR_BASE + LANE_STRIDE * lane_num;
    phy_o     = PHY_W'(32'(idx_i) / NUM_LANE);
    addr_o    = addr_full[ADDR_W-1:0];
    data_o    = WORD[DATA_W-1:0];
  end
endmodule

// File: rtl/phy_cr_port_fanout.sv
module phy_cr_port_fanout #(
  parameter int unsigned NUM_PHY = 2,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PHY_W   = 1
) (
  input  logic                        bus_valid_i,
  input  logic [PHY_W-1:0]            phy_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           data_i,
  input  logic                        wen_i,
  input  logic [NUM_PHY-1:0]          sel_i,
  input  logic [NUM_PHY-1:0]          ack_i,
  output logic [NUM_PHY-1:0]          sel_o,
  output logic [NUM_PHY*ADDR_W-1:0]   addr_o,
  output logic [NUM_PHY*DATA_W-1:0]   data_o,
  output logic [NUM_PHY-1:0]          wen_o,
  output logic                        ack_o
);
  assign sel_o = sel_i;

  for (genvar p = 0; p < NUM_PHY; p++) begin : g_port
    logic hit;
    assign hit = bus_valid_i && (phy_i == PHY_W'(p));
    assign addr_o[p*ADDR_W +: ADDR_W] = hit ? addr_i : '0;
    assign data_o[p*DATA_W +: DATA_W] = hit ? data_i : '0;
    assign wen_o[p] = hit && wen_i;
  end

  always_comb begin
    ack_o = 1'b0;
    for (int p = 0; p < NUM_PHY; p++) begin
      if (phy_i == PHY_W'(p)) ack_o = ack_i[p];
    end
  end
endmodule

// File: rtl/phy_cr_init_seq.sv
module phy_cr_init_seq #(
  parameter int unsigned NUM_PHY       = 2,
  parameter int unsigned NUM_LANE      = 4,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned ADDR_BASE     = 32'h1008,
  parameter int unsigned LANE_STRIDE   = 32'h100,
  parameter int unsigned SETTLE_CYC    = 10,
  parameter int unsigned POLL_CYC      = 500,
  parameter int unsigned TIMEOUT_POLLS = 500
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      timeout_o,
  output logic [NUM_PHY-1:0]        cr_sel_o,
  output logic [NUM_PHY*ADDR_W-1:0] cr_addr_o,
  output logic [NUM_PHY*DATA_W-1:0] cr_wdata_o,
  output logic [NUM_PHY-1:0]        cr_wen_o,
  input  logic [NUM_PHY-1:0]        cr_ack_i
);
  import phy_cr_pkg::*;

  localparam int unsigned NUM_WR = NUM_PHY * NUM_LANE;
  localparam int unsigned IDX_W  = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;
  localparam int unsigned PHY_W  = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;
  localparam int unsigned SET_W  = $clog2(SETTLE_CYC + 1);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(NUM_WR - 1);
  localparam logic [SET_W-1:0] SETTLE_END = SET_W'(SETTLE_CYC - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SET_W-1:0]  settle_q;
  logic [NUM_PHY-1:0] sel_q;
  logic              wen_q, done_q, tmo_q;

  logic              tick, last, restart, run;
  logic              ack_act, bus_valid;
  logic [PHY_W-1:0]  act_phy;
  logic [ADDR_W-1:0] act_addr;
  logic [DATA_W-1:0] act_data;
  logic              hi_exit, hi_tmo, lo_exit, lo_tmo;

  always_comb begin
    hi_exit   = tick && (ack_act || last);
    hi_tmo    = tick && !ack_act && last;
    lo_exit   = tick && (!ack_act || last);
    lo_tmo    = tick && ack_act && last;
    run       = (state_q == ST_ACK_HI) || (state_q == ST_ACK_LO);
    restart   = (state_q == ST_SETUP) || ((state_q == ST_ACK_HI) && hi_exit);
    bus_valid = (state_q == ST_SETUP) || run;
  end

  phy_cr_poll_timer #(
    .POLL_CYC      (POLL_CYC),
    .TIMEOUT_POLLS (TIMEOUT_POLLS)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (run),
    .tick_o    (tick),
    .last_o    (last)
  );

  phy_cr_write_plan #(
    .NUM_LANE    (NUM_LANE),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .IDX_W       (IDX_W),
    .PHY_W       (PHY_W),
    .ADDR_BASE   (ADDR_BASE),
    .LANE_STRIDE (LANE_STRIDE)
  ) u_plan (
    .idx_i  (idx_q),
    .phy_o  (act_phy),
    .addr_o (act_addr),
    .data_o (act_data)
  );

  phy_cr_port_fanout #(
    .NUM_PHY (NUM_PHY),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PHY_W   (PHY_W)
  ) u_fanout (
    .bus_valid_i (bus_valid),
    .phy_i       (act_phy),
    .addr_i      (act_addr),
    .data_i      (act_data),
    .wen_i       (wen_q),
    .sel_i       (sel_q),
    .ack_i       (cr_ack_i),
    .sel_o       (cr_sel_o),
    .addr_o      (cr_addr_o),
    .data_o      (cr_wdata_o),
    .wen_o       (cr_wen_o),
    .ack_o       (ack_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      settle_q <= '0;
      sel_q    <= '0;
      wen_q    <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_SETTLE;
            sel_q    <= '1;
            tmo_q    <= 1'b0;
            settle_q <= '0;
            idx_q    <= '0;
          end
        end
        ST_SETTLE: begin
          if (settle_q == SETTLE_END) state_q <= ST_SETUP;
          else                        settle_q <= settle_q + 1'b1;
        end
        ST_SETUP: begin
          state_q <= ST_ACK_HI;
          wen_q   <= 1'b1;
        end
        ST_ACK_HI: begin
          if (hi_exit) begin
            wen_q   <= 1'b0;
            state_q <= ST_ACK_LO;
          end
          if (hi_tmo) tmo_q <= 1'b1;
        end
        ST_ACK_LO: begin
          if (lo_exit) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_SETUP;
            end
          end
          if (lo_tmo) tmo_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/phy_cr_init_seq_chk.sv
module phy_cr_init_seq_chk #(
  parameter int unsigned NUM_PHY    = 2,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETTLE_CYC = 10
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      start_i,
  input logic                      busy_o,
  input logic                      done_o,
  input logic                      timeout_o,
  input logic [NUM_PHY-1:0]        cr_sel_o,
  input logic [NUM_PHY*ADDR_W-1:0] cr_addr_o,
  input logic [NUM_PHY*DATA_W-1:0] cr_wdata_o,
  input logic [NUM_PHY-1:0]        cr_wen_o,
  input logic [NUM_PHY-1:0]        cr_ack_i
);
  logic [31:0] since_start;
  logic        accepted;

  assign accepted = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      since_start <= '0;
    else if (accepted)                since_start <= '0;
    else if (since_start != '1)       since_start <= since_start + 1;
  end

  AST_START_SELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accepted |=> (busy_o && (&cr_sel_o))); // R2

  AST_WEN_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cr_wen_o & ~cr_sel_o) == '0)); // R2

  AST_SETTLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|cr_wen_o) |-> (since_start >= SETTLE_CYC)); // R3

  AST_SINGLE_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cr_wen_o)); // R4

  AST_BUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cr_wen_o) && $past(|cr_wen_o)) |-> ($stable(cr_addr_o) && $stable(cr_wdata_o))); // R6

  AST_WEN_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|cr_wen_o) |-> ((|($past(cr_wen_o) & $past(cr_ack_i))) || timeout_o)); // R7

  AST_TMO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> $past(accepted)); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_DONE_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R10
endmodule

bind phy_cr_init_seq phy_cr_init_seq_chk #(
  .NUM_PHY    (NUM_PHY),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .SETTLE_CYC (SETTLE_CYC)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o),
  .cr_sel_o   (cr_sel_o),
  .cr_addr_o  (cr_addr_o),
  .cr_wdata_o (cr_wdata_o),
  .cr_wen_o   (cr_wen_o),
  .cr_ack_i   (cr_ack_i)
);

// File: tb/phy_cr_init_seq_tb_top.sv
module phy_cr_init_seq_tb_top;
  localparam int SETTLE = 10;
  localparam int POLL   = 3;
  localparam int TOUT   = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, tmo;
  logic [1:0]  sel, wen;
  logic [1:0]  ack = 2'b00;
  logic [31:0] addr, wdata;

  always #10 clk = ~clk;

  phy_cr_init_seq #(
    .SETTLE_CYC    (SETTLE),
    .POLL_CYC      (POLL),
    .TIMEOUT_POLLS (TOUT)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .busy_o     (busy),
    .done_o     (done),
    .timeout_o  (tmo),
    .cr_sel_o   (sel),
    .cr_addr_o  (addr),
    .cr_wdata_o (wdata),
    .cr_wen_o   (wen),
    .cr_ack_i   (ack)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // PHY model: mode 0 follows wen after a delay, 1 silent, 2 stuck high
  int          ack_mode [2];
  int          ack_dly  [2];
  logic [15:0] hist     [2];

  initial begin
    for (int p = 0; p < 2; p++) begin
      ack_mode[p] = 0;
      ack_dly[p]  = 2;
      hist[p]     = '0;
    end
  end

  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      hist[p] = {hist[p][14:0], wen[p]};
      if (ack_mode[p] == 1)      ack[p] = 1'b0;
      else if (ack_mode[p] == 2) ack[p] = 1'b1;
      else                       ack[p] = hist[p][ack_dly[p]-1];
    end
  end

  // monitor
  int          cyc = 0;
  int          n_wr, done_cnt, done_wide, hold_err, busy_cyc;
  int          log_phy [16];
  logic [15:0] log_addr [16];
  logic [15:0] log_data [16];
  bit          pre_ok [16];
  int          rise_cyc [16];
  int          fall_cyc [16];
  logic [1:0]  prev_wen = '0;
  logic [31:0] prev_addr = '0, prev_wdata = '0;
  logic        prev_done = 1'b0, prev_busy = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (busy && !prev_busy) busy_cyc = cyc;
    if ((|wen) && !(|prev_wen) && n_wr < 16) begin
      for (int p = 0; p < 2; p++) begin
        if (wen[p]) begin
          log_phy[n_wr]  = p;
          log_addr[n_wr] = addr[p*16 +: 16];
          log_data[n_wr] = wdata[p*16 +: 16];
        end
      end
      pre_ok[n_wr]   = (prev_addr == addr) && (prev_wdata == wdata);
      rise_cyc[n_wr] = cyc;
      n_wr++;
    end
    if ((|wen) && (|prev_wen) && ((prev_addr != addr) || (prev_wdata != wdata))) hold_err++;
    if (!(|wen) && (|prev_wen) && n_wr > 0) fall_cyc[n_wr-1] = cyc;
    if (done) begin
      done_cnt++;
      if (prev_done) done_wide++;
    end
    prev_wen = wen; prev_addr = addr; prev_wdata = wdata;
    prev_done = done; prev_busy = busy;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); #1;
    n_wr = 0; done_cnt = 0; done_wide = 0; hold_err = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && done_cnt == 0; i++) begin
      @(negedge clk); #1;
    end
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic check_program(input string tag, input bit exp_tmo);
    check(n_wr == 8, {tag, " R4 write count"}, n_wr, 8);
    for (int k = 0; k < 8 && k < n_wr; k++) begin
      check(log_phy[k] == k / 4, {tag, " R4 target phy"}, log_phy[k], k / 4);
      check(log_addr[k] == 16'(16'h1008 + 16'h100 * (k % 4)), {tag, " R5 lane address"},
            int'(log_addr[k]), 16'h1008 + 16'h100 * (k % 4));
      check(log_data[k] == 16'h0E21, {tag, " R5 data word"}, int'(log_data[k]), 16'h0E21);
      check(pre_ok[k], {tag, " R6 bus set before wen"}, int'(pre_ok[k]), 1);
    end
    check(hold_err == 0, {tag, " R6 bus held"}, hold_err, 0);
    check(done_cnt == 1 && done_wide == 0, {tag, " R10 single done pulse"}, done_cnt, 1);
    check(!busy, {tag, " R10 idle after done"}, int'(busy), 0);
    check(tmo == exp_tmo, {tag, " R8 timeout flag"}, int'(tmo), int'(exp_tmo));
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(!busy && !done && !tmo, "R1 status after reset", {busy, done, tmo}, 0);
    check(sel == 2'b00 && wen == 2'b00, "R1 sel/wen after reset", {sel, wen}, 0);
    check(addr == '0 && wdata == '0, "R1 buses after reset", int'(addr | wdata), 0);
  endtask

  task automatic t_nominal();
    ack_mode[0] = 0; ack_mode[1] = 0; ack_dly[0] = 2; ack_dly[1] = 2;
    clear_mon();
    pulse_start();
    check(busy && sel == 2'b11, "R2 busy and select after start", {busy, sel}, 7);
    wait_done();
    check_program("nominal", 1'b0);
    check(rise_cyc[0] - busy_cyc >= SETTLE, "R3 settle before first write", rise_cyc[0] - busy_cyc, SETTLE);
    for (int k = 0; k < 8; k++) begin
      check((fall_cyc[k] - rise_cyc[k]) % POLL == 0, "R8 wen ends on poll boundary",
            fall_cyc[k] - rise_cyc[k], POLL);
      if (k < 7) check(rise_cyc[k+1] > fall_cyc[k], "R7 next write after release", rise_cyc[k+1], fall_cyc[k]);
    end
    check(sel == 2'b11, "R2 select held after program", int'(sel), 3);
  endtask

  task automatic t_slow();
    ack_mode[0] = 0; ack_mode[1] = 0; ack_dly[0] = 7; ack_dly[1] = 7;
    clear_mon();
    pulse_start();
    wait_done();
    check_program("slow ack", 1'b0);
    for (int k = 0; k < 8; k++)
      check(fall_cyc[k] - rise_cyc[k] >= 7, "R7 wen waits for ack", fall_cyc[k] - rise_cyc[k], 7);
  endtask

  task automatic t_dead_phy1();
    ack_mode[0] = 0; ack_mode[1] = 1; ack_dly[0] = 2;
    clear_mon();
    pulse_start();
    wait_done();
    check_program("dead phy1", 1'b1);
    for (int k = 4; k < 8; k++)
      check(fall_cyc[k] - rise_cyc[k] == POLL * TOUT, "R8 exact abandon time",
            fall_cyc[k] - rise_cyc[k], POLL * TOUT);
    repeat (20) @(negedge clk);
    #1;
    check(tmo == 1'b1, "R9 timeout sticky while idle", int'(tmo), 1);
  endtask

  task automatic t_clear_on_start();
    ack_mode[1] = 0; ack_dly[1] = 2;
    clear_mon();
    pulse_start();
    check(tmo == 1'b0, "R9 timeout cleared by start", int'(tmo), 0);
    wait_done();
    check_program("after clear", 1'b0);
  endtask

  task automatic t_stuck_high();
    ack_mode[0] = 2; ack_mode[1] = 0;
    clear_mon();
    pulse_start();
    wait_done();
    check_program("stuck ack", 1'b1);
    for (int k = 0; k < 4; k++)
      check(rise_cyc[k+1] - fall_cyc[k] >= POLL * TOUT, "R7 release wait times out before next write",
            rise_cyc[k+1] - fall_cyc[k], POLL * TOUT);
    ack_mode[0] = 0;
  endtask

  task automatic t_start_busy();
    ack_mode[0] = 0; ack_mode[1] = 0;
    clear_mon();
    pulse_start();
    repeat (15) @(negedge clk);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    wait_done();
    check_program("start while busy", 1'b0);
    repeat (30) @(negedge clk);
    #1;
    check(n_wr == 8 && !busy, "R11 no extra program", n_wr, 8);
    check(done_cnt == 1, "R11 one done pulse", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nominal();
    t_slow();
    t_dead_phy1();
    t_clear_on_start();
    t_stuck_high();
    t_start_busy();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule